// File: doc/BRIEF.md
# Resumable Framed Serial Result Output Port

This block is the read side of a converter's serial interface, and an external master drives its clock. When a fresh conversion result arrives, the block loads it into a shift register and pulls an active-low ready flag. The master then pulls an active-low frame input and toggles a serial clock that idles low. The block drives the result onto a data line with a separate output enable, which models a three-state pin. The most significant bit appears as soon as the frame is seen. Each later bit moves onto the line on a falling clock edge, so the master samples on rising edges.

The master may release the frame in the middle of a word. The line then goes to high impedance, but the bit position is kept. When the frame is pulled again, the transfer continues from the held position, and a word may be split any number of times. The falling edge after the one that delivers the least significant bit ends the word: ready returns high and the output is disabled. A result that arrives while a read is unfinished is held, and it is loaded once that read ends.

The serial clock and frame inputs are synchronised into the system clock domain, and their edges are detected there. The data and enable outputs are registered.

Top module: `serial_result_port`

## Requirements
- R1: After reset, `ready_n` is 1 and `sdata_oe` is 0.
- R2: A `result_valid` pulse while no read is in progress loads `result_data`, clears the bit position and drives `ready_n` to 0.
- R3: When `frame_n` goes low while `ready_n` is 0, `sdata_oe` becomes 1 and `sdata_out` shows bit DATA_W-1 before any serial clock edge.
- R4: Each falling edge of `sclk`, taken while the frame is low, moves the next lower bit onto `sdata_out`, most significant bit first. The DATA_W-th such edge (the one after the edge that delivers bit 0) sets `ready_n` to 1 and drives `sdata_oe` to 0. `ready_n` rises at no other time.
- R5: When `frame_n` goes high in the middle of a word, `sdata_oe` goes to 0, `ready_n` stays 0 and the bit position is kept.
- R6: When `frame_n` goes low again, the output is re-enabled and the transfer continues from the held bit. Any number of pauses within one word gives the same word as an unbroken read.
- R7: A result that arrives during an unfinished read does not disturb it. After the read completes, that result is loaded and `ready_n` returns to 0.
- R8: Falling `sclk` edges while `frame_n` is high have no effect: `sdata_oe` stays 0 and the next read returns the whole word from its most significant bit.
- R9: If `frame_n` rises within one system clock of a falling `sclk` edge, that edge still advances the bit position exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| result_valid | input | 1 | One-cycle strobe marking a new conversion result |
| result_data | input | DATA_W | Conversion result word |
| sclk | input | 1 | Serial clock from the master, idles low |
| frame_n | input | 1 | Active-low read frame from the master |
| sdata_out | output | 1 | Serial data, meaningful while sdata_oe is 1 |
| sdata_oe | output | 1 | Output enable of the data line; 0 means high impedance |
| ready_n | output | 1 | Active-low data-ready flag |

## Verification
The bench splits words at several bit positions, including a pause before the first edge and one just before the final edge. It also uses repeated pauses within one word. A design that lost or repeated the held position would return a shifted word. The frame is also released one system cycle after a falling clock edge. A design that qualified that edge with the frame's current state would drop a bit there. Clock pulses sent while the frame is high would shift a careless design's register early. A second result that lands mid-read would corrupt the word being read if it were not held until the read ends.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;

  // Events seen in the system clock domain after synchronisation.
  typedef struct packed {
    logic sclk_fall;  // falling edge of the serial clock
    logic act_now;    // frame asserted in the latest sample
    logic act_prev;   // frame asserted in the sample before
  } sp_event_t;

endpackage

// File: rtl/sp_sync_edge.sv
module sp_sync_edge
  import serial_port_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sclk_raw,
  input  logic      frame_n_raw,
  output sp_event_t ev
);

  logic [STAGES-1:0] sclk_q, sclk_d;
  logic [STAGES-1:0] frm_q, frm_d;
  logic              sclk_last_q, act_last_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign sclk_d[g] = sclk_raw;
        assign frm_d[g]  = frame_n_raw;
      end else begin : g_next
        assign sclk_d[g] = sclk_q[g-1];
        assign frm_d[g]  = frm_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q      <= '0;
      frm_q       <= '1;
      sclk_last_q <= 1'b0;
      act_last_q  <= 1'b0;
    end else begin
      sclk_q      <= sclk_d;
      frm_q       <= frm_d;
      sclk_last_q <= sclk_q[STAGES-1];
      act_last_q  <= ~frm_q[STAGES-1];
    end
  end

  always_comb begin
    ev.sclk_fall = sclk_last_q & ~sclk_q[STAGES-1];
    ev.act_now   = ~frm_q[STAGES-1];
    ev.act_prev  = act_last_q;
  end

endmodule

// File: rtl/sp_shifter.sv
module sp_shifter #(
  parameter int DATA_W = 24,
  localparam int CW    = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_word,
  input  logic              shift_en,
  output logic              msb_next,
  output logic [CW-1:0]     bit_cnt,
  output logic              at_last
);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CW-1:0]     cnt_q, cnt_d;

  assign at_last = (cnt_q == CW'(DATA_W - 1));

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (load) begin
      sh_d  = load_word;
      cnt_d = '0;
    end else if (shift_en) begin
      if (at_last) begin
        cnt_d = '0;                         // word-ending edge
      end else begin
        sh_d  = {sh_q[DATA_W-2:0], 1'b0};
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign msb_next = sh_d[DATA_W-1];
  assign bit_cnt  = cnt_q;

endmodule

// File: rtl/sp_ready_ctrl.sv
module sp_ready_ctrl
  import serial_port_pkg::*;
#(
  parameter int DATA_W = 24,
  localparam int CW    = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sp_event_t         ev,
  input  logic              result_valid,
  input  logic [DATA_W-1:0] result_data,
  input  logic [CW-1:0]     bit_cnt,
  input  logic              at_last,
  output logic              load,
  output logic [DATA_W-1:0] load_word,
  output logic              shift_en,
  output logic              ready_n_next,
  output logic              ready_n
);

  logic              rdy_n_q;
  logic              pend_q, pend_d;
  logic [DATA_W-1:0] pword_q, pword_d;
  logic              busy, finish;

  always_comb begin
    // The frame sampled before the edge qualifies it: the frame only
    // changes while the clock is low, so that sample is settled.
    shift_en     = ev.sclk_fall & ev.act_prev & ~rdy_n_q;
    finish       = shift_en & at_last;
    busy         = ~rdy_n_q & ((bit_cnt != '0) | ev.act_now | ev.act_prev);
    load         = (result_valid | pend_q) & ~busy;
    load_word    = result_valid ? result_data : pword_q;
    ready_n_next = rdy_n_q;
    if (load)        ready_n_next = 1'b0;
    else if (finish) ready_n_next = 1'b1;
    pend_d  = pend_q;
    pword_d = pword_q;
    if (result_valid && busy) begin
      pend_d  = 1'b1;
      pword_d = result_data;
    end else if (load) begin
      pend_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_n_q <= 1'b1;
      pend_q  <= 1'b0;
      pword_q <= '0;
    end else begin
      rdy_n_q <= ready_n_next;
      pend_q  <= pend_d;
      if (result_valid && busy) pword_q <= pword_d;
    end
  end

  assign ready_n = rdy_n_q;

endmodule

// File: rtl/serial_result_port.sv
module serial_result_port
  import serial_port_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int SYNC_STAGES = 2,
  localparam int CW         = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              result_valid,
  input  logic [DATA_W-1:0] result_data,
  input  logic              sclk,
  input  logic              frame_n,
  output logic              sdata_out,
  output logic              sdata_oe,
  output logic              ready_n
);

  sp_event_t         ev_s;
  logic              load, shift_en, msb_next, at_last, rdy_n_next;
  logic [DATA_W-1:0] load_word;
  logic [CW-1:0]     bit_cnt;
  logic              oe_d, dout_d, oe_q, dout_q;

  sp_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_raw(sclk), .frame_n_raw(frame_n), .ev(ev_s)
  );

  sp_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_word(load_word),
    .shift_en(shift_en), .msb_next(msb_next), .bit_cnt(bit_cnt), .at_last(at_last)
  );

  sp_ready_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ev(ev_s), .result_valid(result_valid),
    .result_data(result_data), .bit_cnt(bit_cnt), .at_last(at_last),
    .load(load), .load_word(load_word), .shift_en(shift_en),
    .ready_n_next(rdy_n_next), .ready_n(ready_n)
  );

  always_comb begin
    oe_d   = ev_s.act_now & ~rdy_n_next;
    dout_d = oe_d & msb_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= 1'b0;
      dout_q <= 1'b0;
    end else begin
      oe_q   <= oe_d;
      dout_q <= dout_d;
    end
  end

  assign sdata_oe  = oe_q;
  assign sdata_out = dout_q;

endmodule

// File: rtl/serial_result_port_chk.sv
module serial_result_port_chk #(
  parameter int DATA_W = 24,
  parameter int CW     = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ready_n,
  input logic          sdata_oe,
  input logic          act_now,
  input logic          act_prev,
  input logic [CW-1:0] bit_cnt
);

  assert_oe_needs_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sdata_oe |-> !ready_n);

  assert_oe_off_frame_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !act_now |=> !sdata_oe);

  assert_ready_rise_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_n) |-> ($past(bit_cnt) == CW'(DATA_W - 1)));

  assert_cnt_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt < CW'(DATA_W));

  assert_fresh_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_n) |-> (bit_cnt == '0));

  assert_no_shift_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !act_prev |=> ($stable(bit_cnt) || bit_cnt == '0));

endmodule

bind serial_result_port serial_result_port_chk #(.DATA_W(DATA_W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready_n(ready_n), .sdata_oe(sdata_oe),
  .act_now(ev_s.act_now), .act_prev(ev_s.act_prev), .bit_cnt(bit_cnt)
);

// File: tb/serial_result_port_bench.sv
module serial_result_port_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 24;
  localparam int HALF       = 6;
  localparam int NVEC       = 5;
  // {split position (8 bits), data word (24 bits)}; split of DATA_W means unbroken
  localparam logic [31:0] VECS [NVEC] = '{
    32'h18_A5C3F1, 32'h0C_123456, 32'h00_FFFFFF, 32'h17_800001, 32'h01_5A5A5A
  };

  logic              clk, rst_n, result_valid, sclk, frame_n;
  logic [DATA_W-1:0] result_data;
  logic              sdata_out, sdata_oe, ready_n;
  int                checks, fails;
  bit                done;

  serial_result_port #(.DATA_W(DATA_W)) u_serial_result_port (
    .clk(clk), .rst_n(rst_n), .result_valid(result_valid), .result_data(result_data),
    .sclk(sclk), .frame_n(frame_n), .sdata_out(sdata_out), .sdata_oe(sdata_oe),
    .ready_n(ready_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [DATA_W-1:0] d);
    @(negedge clk); result_valid = 1'b1; result_data = d;
    @(negedge clk); result_valid = 1'b0;
  endtask

  // Sample, then give one clock pulse; last low phase lasts 'tail' cycles.
  task automatic read_seg(input int nbits, input int tail,
                          inout logic [DATA_W-1:0] word, inout int pos);
    for (int i = 0; i < nbits; i++) begin
      if (pos < DATA_W) word[DATA_W-1-pos] = sdata_out;
      pos++;
      sclk = 1'b1; wait_n(HALF);
      sclk = 1'b0; wait_n((i == nbits-1) ? tail : HALF);
    end
  endtask

  task automatic full_read(input logic [DATA_W-1:0] d, input int split, input int tail,
                           input bit check_ready, input string tag);
    logic [DATA_W-1:0] w;
    int pos;
    w = '0; pos = 0;
    frame_n = 1'b0; wait_n(HALF);
    chk(sdata_oe === 1'b1 && sdata_out === d[DATA_W-1], {tag, " R3 msb on frame"},
        {sdata_oe, sdata_out}, {1'b1, d[DATA_W-1]});
    read_seg(split, (split < DATA_W) ? tail : HALF, w, pos);
    if (split < DATA_W) begin
      frame_n = 1'b1; wait_n(HALF);
      chk(sdata_oe === 1'b0 && ready_n === 1'b0, {tag, " R5 paused"},
          {sdata_oe, ready_n}, 2'b00);
      frame_n = 1'b0; wait_n(HALF);
      chk(sdata_oe === 1'b1, {tag, " R6 resumed"}, sdata_oe, 1'b1);
      read_seg(DATA_W - split, HALF, w, pos);
    end
    chk(sdata_oe === 1'b0, {tag, " R4 output off after word"}, sdata_oe, 1'b0);
    if (check_ready) chk(ready_n === 1'b1, {tag, " R4 ready high"}, ready_n, 1'b1);
    frame_n = 1'b1; wait_n(HALF);
    chk(w === d, {tag, " R4 R6 word"}, w, d);
  endtask

  initial begin
    int n;
    n = 0;
    while (!done && n < 200000) begin @(posedge clk); n++; end
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", n);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] w;
    int pos;
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; result_valid = 1'b0; result_data = '0; sclk = 1'b0; frame_n = 1'b1;
    wait_n(4);
    chk(ready_n === 1'b1 && sdata_oe === 1'b0, "R1 reset", {ready_n, sdata_oe}, 2'b10);
    rst_n = 1'b1; wait_n(3);

    for (int v = 0; v < NVEC; v++) begin
      load(VECS[v][DATA_W-1:0]); wait_n(2);
      chk(ready_n === 1'b0, "R2 ready low on load", ready_n, 1'b0);
      full_read(VECS[v][DATA_W-1:0], int'(VECS[v][31:24]), HALF, 1'b1, "vec");
    end

    // R6: several pauses in one word
    load(24'hC3A50F); wait_n(2);
    w = '0; pos = 0;
    for (int s = 0; s < 4; s++) begin
      frame_n = 1'b0; wait_n(HALF);
      read_seg(6, HALF, w, pos);
      if (s < 3) begin frame_n = 1'b1; wait_n(HALF); end
    end
    frame_n = 1'b1; wait_n(HALF);
    chk(w === 24'hC3A50F && ready_n === 1'b1, "R6 four segments", w, 24'hC3A50F);

    // R8: falling edges with frame high are ignored
    load(24'h9E3779); wait_n(2);
    for (int k = 0; k < 3; k++) begin
      sclk = 1'b1; wait_n(HALF); sclk = 1'b0; wait_n(HALF);
      chk(sdata_oe === 1'b0, "R8 oe stays off", sdata_oe, 1'b0);
    end
    full_read(24'h9E3779, DATA_W, HALF, 1'b1, "R8");

    // R9: frame released one system cycle after a falling edge
    load(24'h6B1D2F); wait_n(2);
    full_read(24'h6B1D2F, 9, 1, 1'b1, "R9");

    // R7: result arriving mid-read is held
    load(24'h0F0F33); wait_n(2);
    frame_n = 1'b0; wait_n(HALF);
    w = '0; pos = 0;
    read_seg(5, HALF, w, pos);
    load(24'hE4C2B1); wait_n(2);
    chk(ready_n === 1'b0, "R7 ready held low mid-read", ready_n, 1'b0);
    frame_n = 1'b1; wait_n(HALF);
    frame_n = 1'b0; wait_n(HALF);
    read_seg(DATA_W - 5, HALF, w, pos);
    frame_n = 1'b1; wait_n(HALF);
    chk(w === 24'h0F0F33, "R7 first word intact", w, 24'h0F0F33);
    chk(ready_n === 1'b0, "R7 held result loaded", ready_n, 1'b0);
    full_read(24'hE4C2B1, DATA_W, HALF, 1'b1, "R7 second");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule